// File: doc/BRIEF.md
# Multi-mode DMA address generator

This block produces the sequence of byte addresses that one side of a DMA channel (either the read side or the write side) walks through during a transfer. A one-cycle load pulse captures the whole configuration: the first address, the address mode, the element size, the frame shape, and two signed skip values. After the load, every step strobe moves the generator on by one element access.

For the access now pending, the generator presents the address and two flags. One flag marks the final element of the current frame. The other marks the final frame of the block. A finished flag rises once the last element of the block has been stepped past. Two error flags, captured at load time, report a start address that does not fit the element size and a mode code with no meaning.

Five modes cover the common access patterns: a fixed register address, incrementing or decrementing buffers, strided 1D access, and 2D access with a separate skip applied at each frame boundary. The block does not issue bus cycles, move data, build bursts or fetch descriptors.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `done` is 1 and `addr`, `last_elem`, `last_frame`, `align_err` and `mode_err` are 0. While `done` is 1, a `step` changes none of the outputs until the next `start`.
- R2: The cycle after `start` is sampled, `addr` equals `cfg_addr`, `done` is 0, `last_elem` is 1 exactly when `cfg_elems` is 1, and `last_frame` is 1 exactly when `cfg_frames` is 1. When `start` and `step` arrive together, `start` takes priority.
- R3: Mode code 0 (fixed): `addr` does not change on any step.
- R4: Mode code 1 (increment) adds the element size to `addr` on each step. Mode code 2 (decrement) subtracts it. The element size is 2^`cfg_size` bytes, with `cfg_size` codes 0..3 giving 1, 2, 4 and 8 bytes.
- R5: Mode code 3 (1D strided): each step adds the element size plus the signed `cfg_elem_skip`.
- R6: Mode code 4 (2D strided): a step within a frame adds the element size plus `cfg_elem_skip`. A step from the last element of a frame also adds the signed `cfg_frame_skip`.
- R7: The block is `cfg_elems` × `cfg_frames` accesses long. `last_elem` is 1 on the final element of each frame. `last_frame` is 1 throughout the final frame.
- R8: A step taken on the final element of the final frame sets `done` to 1 and leaves `addr` unchanged.
- R9: If `cfg_elems` or `cfg_frames` is 0, `done` is 1 in the cycle after `start`, and both last flags are 0.
- R10: When `cfg_align_chk` is 1 at `start`, `align_err` becomes 1 if `cfg_addr` is not a multiple of the element size. Otherwise it becomes 0. It holds this value until the next `start`.
- R11: Mode codes 5..7 behave as mode 0 and set `mode_err` to 1 until the next `start`. Codes 0..4 clear it.
- R12: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load pulse that captures the configuration |
| cfg_addr | input | 32 | First address of the block |
| cfg_mode | input | 3 | Address mode code (0..4 valid) |
| cfg_size | input | 2 | log2 of the element size in bytes |
| cfg_elems | input | 16 | Elements per frame |
| cfg_frames | input | 16 | Frames per block |
| cfg_elem_skip | input | 32 | Signed element skip in bytes |
| cfg_frame_skip | input | 32 | Signed frame skip in bytes |
| cfg_align_chk | input | 1 | Enables the start-alignment check |
| step | input | 1 | Advance by one element access |
| addr | output | 32 | Address of the pending access |
| last_elem | output | 1 | Pending access is the last of its frame |
| last_frame | output | 1 | Pending access lies in the last frame |
| done | output | 1 | Block finished, or idle |
| align_err | output | 1 | Start address misaligned (latched at start) |
| mode_err | output | 1 | Reserved mode code (latched at start) |

## Verification
The assertions assume that the configuration inputs matter only in the cycle where `start` is high, and that `step` may arrive in any cycle, including while the block is idle or in the same cycle as `start`. The stimulus changes the configuration only alongside `start`. It drives steps with random idle gaps between them, and it deliberately sends steps while the block is done. Frame shapes are kept small (1 to 5 elements, 1 to 4 frames) so that every frame boundary is reached many times. The skips mix small signed values with full 32-bit random values, and the start address is placed near the top of the address space, so wrap-around is exercised in every mode.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  typedef enum logic [2:0] {
    AM_FIXED    = 3'd0,
    AM_INCR     = 3'd1,
    AM_DECR     = 3'd2,
    AM_STRIDE1D = 3'd3,
    AM_STRIDE2D = 3'd4
  } am_mode_e;

  localparam int unsigned AM_LAST_VALID = 4;

  function automatic logic mode_is_valid(input logic [2:0] code);
    return (32'(code) <= AM_LAST_VALID);
  endfunction

endpackage

// File: rtl/dma_ag_delta.sv
module dma_ag_delta
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        mode_q,
  input  logic [1:0]        size_q,
  input  logic [ADDR_W-1:0] eskip_q,
  input  logic [ADDR_W-1:0] fskip_q,
  input  logic              frame_end,
  output logic [ADDR_W-1:0] delta
);

  logic [ADDR_W-1:0] size_bytes;
  logic [ADDR_W-1:0] stride;

  assign size_bytes = ADDR_W'(1) << size_q;
  assign stride     = size_bytes + eskip_q;

  always_comb begin
    unique case (mode_q)
      3'(AM_INCR):     delta = size_bytes;
      3'(AM_DECR):     delta = ADDR_W'(0) - size_bytes;
      3'(AM_STRIDE1D): delta = stride;
      3'(AM_STRIDE2D): delta = frame_end ? (stride + fskip_q) : stride;
      default:         delta = '0;
    endcase
  end

endmodule

// File: rtl/dma_ag_counter.sv
module dma_ag_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] elems,
  input  logic [CNT_W-1:0] frames,
  input  logic             step,
  output logic             last_elem,
  output logic             last_frame,
  output logic             done,
  output logic             advance
);

  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);
  localparam logic [CNT_W:0] TWO = (CNT_W+1)'(2);

  logic [CNT_W-1:0] elem_idx, frame_idx, elems_q, frames_q;
  logic             final_acc, do_step, zero_len;
  logic [CNT_W:0]   elem_next2, frame_next2;

  assign final_acc   = last_elem && last_frame;
  assign do_step     = step && !load && !done;
  assign advance     = do_step && !final_acc;
  assign zero_len    = (elems == '0) || (frames == '0);
  assign elem_next2  = {1'b0, elem_idx} + TWO;
  assign frame_next2 = {1'b0, frame_idx} + TWO;

  always_ff @(posedge clk) begin
    if (rst) begin
      elem_idx   <= '0;
      frame_idx  <= '0;
      elems_q    <= '0;
      frames_q   <= '0;
      last_elem  <= 1'b0;
      last_frame <= 1'b0;
      done       <= 1'b1;
    end else if (load) begin
      elem_idx   <= '0;
      frame_idx  <= '0;
      elems_q    <= elems;
      frames_q   <= frames;
      last_elem  <= !zero_len && ({1'b0, elems} == ONE);
      last_frame <= !zero_len && ({1'b0, frames} == ONE);
      done       <= zero_len;
    end else if (do_step) begin
      if (final_acc) begin
        done <= 1'b1;
      end else if (last_elem) begin
        elem_idx   <= '0;
        frame_idx  <= frame_idx + 1'b1;
        last_elem  <= ({1'b0, elems_q} == ONE);
        last_frame <= (frame_next2 == {1'b0, frames_q});
      end else begin
        elem_idx  <= elem_idx + 1'b1;
        last_elem <= (elem_next2 == {1'b0, elems_q});
      end
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done && !load |=> done);                                  // R1
  AST_ELEM_RANGE: assert property (@(posedge clk) disable iff (rst)
    !done |-> (elem_idx < elems_q) && (frame_idx < frames_q)); // R7
  AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (rst)
    step && !load && !done && last_elem && last_frame |=> done); // R8

endmodule

// File: rtl/dma_ag_cfg_check.sv
module dma_ag_cfg_check
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        mode,
  input  logic [1:0]        size,
  input  logic              chk_en,
  output logic              align_err,
  output logic              mode_err
);

  logic [ADDR_W-1:0] low_mask;
  assign low_mask = (ADDR_W'(1) << size) - ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      align_err <= 1'b0;
      mode_err  <= 1'b0;
    end else if (load) begin
      align_err <= chk_en && ((start_addr & low_mask) != '0);
      mode_err  <= !mode_is_valid(mode);
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(mode_err) && $stable(align_err)); // R10
  AST_CHK_OFF_CLEAN: assert property (@(posedge clk) disable iff (rst)
    load && !chk_en |=> !align_err);                    // R10

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [2:0]        cfg_mode,
  input  logic [1:0]        cfg_size,
  input  logic [CNT_W-1:0]  cfg_elems,
  input  logic [CNT_W-1:0]  cfg_frames,
  input  logic [ADDR_W-1:0] cfg_elem_skip,
  input  logic [ADDR_W-1:0] cfg_frame_skip,
  input  logic              cfg_align_chk,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last_elem,
  output logic              last_frame,
  output logic              done,
  output logic              align_err,
  output logic              mode_err
);

  logic [2:0]        mode_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] eskip_q, fskip_q, delta;
  logic              advance;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 3'(AM_FIXED);
      size_q  <= '0;
      eskip_q <= '0;
      fskip_q <= '0;
      addr    <= '0;
    end else if (start) begin
      mode_q  <= cfg_mode;
      size_q  <= cfg_size;
      eskip_q <= cfg_elem_skip;
      fskip_q <= cfg_frame_skip;
      addr    <= cfg_addr;
    end else if (advance) begin
      addr    <= addr + delta;
    end
  end

  dma_ag_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .load       (start),
    .elems      (cfg_elems),
    .frames     (cfg_frames),
    .step       (step),
    .last_elem  (last_elem),
    .last_frame (last_frame),
    .done       (done),
    .advance    (advance)
  );

  dma_ag_delta #(.ADDR_W(ADDR_W)) delta_i (
    .mode_q    (mode_q),
    .size_q    (size_q),
    .eskip_q   (eskip_q),
    .fskip_q   (fskip_q),
    .frame_end (last_elem),
    .delta     (delta)
  );

  dma_ag_cfg_check #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .load       (start),
    .start_addr (cfg_addr),
    .mode       (cfg_mode),
    .size       (cfg_size),
    .chk_en     (cfg_align_chk),
    .align_err  (align_err),
    .mode_err   (mode_err)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> $stable(addr) && $stable(last_elem) && $stable(last_frame)); // R1
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    start |=> addr == $past(cfg_addr));                                            // R2
  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start && (mode_q == 3'(AM_FIXED) || mode_err) |=> $stable(addr));              // R3
  AST_INCR_STEP: assert property (@(posedge clk) disable iff (rst)
    step && !start && !done && !(last_elem && last_frame) && mode_q == 3'(AM_INCR)
    |=> addr == $past(addr) + (ADDR_W'(1) << $past(size_q)));                      // R4
  AST_RSV_FLAG: assert property (@(posedge clk) disable iff (rst)
    start && !mode_is_valid(cfg_mode) |=> mode_err);                                // R11

endmodule

// File: tb/dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, step, cfg_align_chk;
  logic [31:0] cfg_addr, cfg_elem_skip, cfg_frame_skip;
  logic [2:0]  cfg_mode;
  logic [1:0]  cfg_size;
  logic [15:0] cfg_elems, cfg_frames;
  logic [31:0] addr;
  logic        last_elem, last_frame, done, align_err, mode_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_addr_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_addr(cfg_addr), .cfg_mode(cfg_mode),
    .cfg_size(cfg_size), .cfg_elems(cfg_elems), .cfg_frames(cfg_frames),
    .cfg_elem_skip(cfg_elem_skip), .cfg_frame_skip(cfg_frame_skip),
    .cfg_align_chk(cfg_align_chk), .step(step), .addr(addr), .last_elem(last_elem),
    .last_frame(last_frame), .done(done), .align_err(align_err), .mode_err(mode_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [2:0] m, input logic [1:0] sc,
                                             input logic [31:0] a, input logic [31:0] es,
                                             input logic [31:0] fs, input bit eof);
    logic [31:0] sz;
    sz = 32'd1 << sc;
    case (m)
      3'd1: return a + sz;
      3'd2: return a - sz;
      3'd3: return a + sz + es;
      3'd4: return a + sz + es + (eof ? fs : 32'd0);
      default: return a;
    endcase
  endfunction

  task automatic do_start(input logic [31:0] a, input logic [2:0] m, input logic [1:0] sc,
                          input int ne, input int nf, input logic [31:0] es,
                          input logic [31:0] fs, input bit chk, input bit with_step);
    cfg_addr = a; cfg_mode = m; cfg_size = sc; cfg_elems = 16'(ne); cfg_frames = 16'(nf);
    cfg_elem_skip = es; cfg_frame_skip = fs; cfg_align_chk = chk;
    start = 1'b1; step = with_step;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
  endtask

  task automatic pulse_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic run_block(input logic [31:0] a, input logic [2:0] m, input logic [1:0] sc,
                           input int ne, input int nf, input logic [31:0] es,
                           input logic [31:0] fs, input int max_gap);
    logic [31:0] exp_a;
    bit bad_mode;
    exp_a = a;
    bad_mode = (m > 3'd4);
    do_start(a, m, sc, ne, nf, es, fs, 1'b0, 1'b0);
    check(addr == a, "R2 load address", addr, a);
    check(done == 1'b0, "R2 done clear", 32'(done), 0);
    check(mode_err == bad_mode, "R11 mode_err", 32'(mode_err), 32'(bad_mode));
    for (int f = 0; f < nf; f++) begin
      for (int e = 0; e < ne; e++) begin
        check(addr == exp_a, (m == 3'd4) ? "R6 2D address" : (m == 3'd3) ? "R5 1D address" :
              (m == 3'd1 || m == 3'd2) ? "R4 inc/dec address" : "R3/R11 fixed address", addr, exp_a);
        check(last_elem == (e == ne-1), "R7 last_elem", 32'(last_elem), 32'(e == ne-1));
        check(last_frame == (f == nf-1), "R7 last_frame", 32'(last_frame), 32'(f == nf-1));
        check(done == 1'b0, "R8 done early", 32'(done), 0);
        for (int g = 0, gaps = int'($urandom_range(0, max_gap)); g < gaps; g++) @(negedge clk);
        pulse_step();
        if (!(e == ne-1 && f == nf-1)) exp_a = model_next(m, sc, exp_a, es, fs, e == ne-1);
      end
    end
    check(done == 1'b1, "R8 done after final", 32'(done), 1);
    check(addr == exp_a, "R8 address held at end", addr, exp_a);
    pulse_step();
    check(addr == exp_a, "R1 step after done ignored", addr, exp_a);
    check(done == 1'b1, "R1 done stays", 32'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; step = 1'b0; cfg_addr = '0; cfg_mode = '0; cfg_size = '0;
    cfg_elems = '0; cfg_frames = '0; cfg_elem_skip = '0; cfg_frame_skip = '0; cfg_align_chk = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R1 reset done", 32'(done), 1);
    check(addr == 32'd0, "R1 reset addr", addr, 0);
    check({last_elem, last_frame, align_err, mode_err} == 4'b0, "R1 reset flags",
          32'({last_elem, last_frame, align_err, mode_err}), 0);
    pulse_step();
    check(addr == 32'd0 && done, "R1 step while idle", addr, 0);

    // R12 wrap upward and downward
    run_block(32'hFFFF_FFF8, 3'd1, 2'd2, 4, 1, 32'd0, 32'd0, 0);
    run_block(32'h0000_0002, 3'd2, 2'd1, 3, 2, 32'd0, 32'd0, 1);
    // R6 negative frame skip, R5 negative element skip
    run_block(32'h1000_0000, 3'd4, 2'd2, 3, 3, 32'd4, 32'hFFFF_FFD0, 0);
    run_block(32'h2000_0100, 3'd3, 2'd3, 5, 2, 32'hFFFF_FFE0, 32'd99, 1);
    // R3 fixed, R11 reserved codes
    run_block(32'h4000_0010, 3'd0, 2'd0, 2, 3, 32'd8, 32'd8, 0);
    run_block(32'h4000_0020, 3'd6, 2'd2, 3, 2, 32'd8, 32'd16, 0);

    // R10 alignment
    do_start(32'h0000_1006, 3'd1, 2'd2, 2, 1, 0, 0, 1'b1, 1'b0);
    check(align_err == 1'b1, "R10 misaligned flagged", 32'(align_err), 1);
    pulse_step();
    check(align_err == 1'b1, "R10 flag held", 32'(align_err), 1);
    check(addr == 32'h0000_100A, "R4 misaligned still steps", addr, 32'h0000_100A);
    do_start(32'h0000_1008, 3'd1, 2'd3, 2, 1, 0, 0, 1'b1, 1'b0);
    check(align_err == 1'b0, "R10 aligned clean", 32'(align_err), 0);
    do_start(32'h0000_1001, 3'd1, 2'd1, 2, 1, 0, 0, 1'b0, 1'b0);
    check(align_err == 1'b0, "R10 check disabled", 32'(align_err), 0);

    // R9 zero length
    do_start(32'h0000_5000, 3'd1, 2'd0, 0, 3, 0, 0, 1'b0, 1'b0);
    check(done == 1'b1 && !last_elem && !last_frame, "R9 zero elems",
          32'({done, last_elem, last_frame}), 32'b100);
    do_start(32'h0000_5000, 3'd1, 2'd0, 2, 0, 0, 0, 1'b0, 1'b0);
    check(done == 1'b1, "R9 zero frames", 32'(done), 1);
    pulse_step();
    check(addr == 32'h0000_5000, "R9 step ignored", addr, 32'h0000_5000);

    // R2 start wins over simultaneous step
    do_start(32'h0000_7000, 3'd1, 2'd2, 3, 1, 0, 0, 1'b0, 1'b1);
    check(addr == 32'h0000_7000, "R2 start beats step", addr, 32'h0000_7000);
    check(last_elem == 1'b0, "R2 first element flag", 32'(last_elem), 0);

    // Random blocks
    for (int t = 0; t < 60; t++) begin
      logic [2:0]  m;
      logic [1:0]  sc;
      logic [31:0] a, es, fs;
      m  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      sc = 2'($urandom_range(0, 3));
      a  = ($urandom_range(0, 3) == 0) ? (32'hFFFF_FFC0 | 32'($urandom_range(0, 63))) : $urandom;
      a  = a & ~((32'd1 << sc) - 32'd1);
      es = ($urandom_range(0, 2) == 0) ? $urandom : 32'($urandom_range(0, 64)) - 32'd32;
      fs = ($urandom_range(0, 2) == 0) ? $urandom : 32'($urandom_range(0, 256)) - 32'd128;
      run_block(a, m, sc, int'($urandom_range(1, 5)), int'($urandom_range(1, 4)), es, fs, 2);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule